// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block is the host-side master for an asynchronous, byte-wide NOR flash bus. A client hands it one request at a time: program a run of consecutive bytes taken from a streaming source, erase the block that holds a given address, or erase the whole array. The block turns each request into the unlock and command write cycles the flash expects, writes the data bytes, then polls the array with read cycles until the embedded operation is reported finished. It finishes with a one-cycle done pulse, or with a one-cycle timeout pulse if the operation overruns its time budget.

All bus timing is counted in clock cycles set by parameters: address and data setup before the write strobe falls, strobe low width, hold after the strobe rises, bus recovery with chip select high, and the output-enable width of a status read. Completion is recognised in two ways: the polled bit 7 agreeing with the target value, or bit 6 reading the same in two consecutive polls. Byte programs and erases each have their own cycle limit.

Top module: `flash_pe_seq`

## Requirements
- R1: Out of reset, fl_ce_n, fl_we_n and fl_oe_n are high, fl_dq_oe is low, req_ready is high and neither op_done nor op_timeout is asserted.
- R2: A program request (req_op = 2'b00) of req_len bytes issues, for each byte in turn, the writes AAh at 555h, 55h at 2AAh, A0h at 555h and then the next source byte at its target address; the targets are req_addr, req_addr+1, ... and exactly one source byte is taken (src_ready high while src_valid is high) per target.
- R3: After each data write the block polls the target address; a poll is complete when read bit 7 equals bit 7 of the written byte, or when bit 6 of the read matches bit 6 of the previous poll of the same byte. Then the next byte starts; after the last byte op_done pulses for one cycle.
- R4: A block erase (req_op = 2'b01) issues AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 30h at req_addr, then polls req_addr until a read returns FFh or bit 6 stops changing, then pulses op_done.
- R5: A chip erase (req_op = 2'b10) issues the same first five writes and then 10h at 555h, and completes by the same rule as R4.
- R6: Every write cycle holds chip enable low with address and data stable for exactly T_SU + T_WP + T_HLD cycles, of which the write strobe is low for exactly T_WP cycles in the middle; chip enable then stays high for at least T_REC cycles before the next cycle.
- R7: Every status read holds output enable low for exactly T_RD cycles inside a chip-enable window of T_SU + T_RD cycles; fl_dq_oe is high only during write cycles and never while fl_oe_n is low.
- R8: If a byte program is still incomplete at a poll that ends PROG_LIMIT or more cycles after its data write, op_timeout pulses instead of op_done and the remaining bytes are neither fetched nor written.
- R9: An erase still incomplete at a poll ending ERASE_LIMIT or more cycles after its last command write ends with op_timeout.
- R10: A program request with req_len = 0, or a request with the reserved code req_op = 2'b11, pulses op_done without any bus cycle.
- R11: req_ready is high only when idle; a req_valid pulse while a request runs is ignored and adds no bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 00 program, 01 block erase, 10 chip erase, 11 reserved |
| req_addr | input | ADDR_W | First program address, or an address inside the block to erase |
| req_len | input | LEN_W | Number of bytes to program |
| src_valid | input | 1 | Source byte available |
| src_ready | output | 1 | Source byte taken this cycle |
| src_data | input | 8 | Source byte |
| op_done | output | 1 | One-cycle pulse: request finished |
| op_timeout | output | 1 | One-cycle pulse: request abandoned on its time limit |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_o | output | 8 | Data driven onto the flash bus |
| fl_dq_oe | output | 1 | Enable for fl_dq_o onto the bus |
| fl_dq_i | input | 8 | Data read from the flash bus |

## Verification
Programming is swept over three start addresses and lengths one to four with arithmetic byte patterns holding both values of bit 7, which separates address stepping, byte order and source consumption errors. A flash model that keeps bit 7 wrong after finishing forces completion through the bit-6 route alone, while a model that never finishes exercises both time limits and proves the remaining bytes are dropped. Block erase at an unaligned address and chip erase are told apart by their final write and by which memory survives, and zero-length, reserved-code and mid-operation requests show that no bus cycle is issued where none is due.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
   localparam int FSEQ_DW = 8;

   typedef enum logic [1:0] {
      OP_PROG   = 2'b00,
      OP_BERASE = 2'b01,
      OP_CERASE = 2'b10,
      OP_RSVD   = 2'b11
   } fseq_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_DATA,
      ST_POLL,
      ST_OK,
      ST_ERR
   } fseq_state_e;

   typedef enum logic [2:0] {
      BC_IDLE,
      BC_SETUP,
      BC_ACT,
      BC_HOLD,
      BC_RECOV
   } fseq_bus_e;

   function automatic int fseq_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/fseq_bus_cycle.sv
module fseq_bus_cycle
   import fseq_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DW     = 8,
   parameter int T_SU   = 1,
   parameter int T_WP   = 9,
   parameter int T_HLD  = 3,
   parameter int T_REC  = 5,
   parameter int T_RD   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic              done,
   output logic [DW-1:0]     rdata,
   output logic              ce_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [ADDR_W-1:0] a_o,
   output logic [DW-1:0]     d_o,
   output logic              d_oe,
   input  logic [DW-1:0]     d_i
);
   localparam int TMAX = fseq_max(fseq_max(fseq_max(T_SU, T_WP), fseq_max(T_HLD, T_REC)), T_RD);
   localparam int CW   = $clog2(TMAX + 1);

   if (T_SU < 1 || T_WP < 1 || T_HLD < 1 || T_REC < 1 || T_RD < 1) begin : g_bad_timing
      $error("fseq_bus_cycle: every phase length must be at least one cycle");
   end

   fseq_bus_e       ph;
   logic [CW-1:0]   cnt;
   logic            rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= BC_IDLE;
         cnt   <= '0;
         rd_q  <= 1'b0;
         done  <= 1'b0;
         rdata <= '0;
         ce_n  <= 1'b1;
         we_n  <= 1'b1;
         oe_n  <= 1'b1;
         a_o   <= '0;
         d_o   <= '0;
         d_oe  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (ph)
            BC_IDLE: begin
               if (start) begin
                  ph   <= BC_SETUP;
                  cnt  <= CW'(T_SU - 1);
                  rd_q <= rd;
                  a_o  <= addr;
                  d_o  <= wdata;
                  ce_n <= 1'b0;
                  d_oe <= !rd;
               end
            end
            BC_SETUP: begin
               if (cnt == '0) begin
                  ph <= BC_ACT;
                  if (rd_q) begin
                     cnt  <= CW'(T_RD - 1);
                     oe_n <= 1'b0;
                  end else begin
                     cnt  <= CW'(T_WP - 1);
                     we_n <= 1'b0;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            BC_ACT: begin
               if (cnt == '0) begin
                  if (rd_q) begin
                     rdata <= d_i;
                     oe_n  <= 1'b1;
                     ce_n  <= 1'b1;
                     ph    <= BC_RECOV;
                     cnt   <= CW'(T_REC - 1);
                  end else begin
                     we_n <= 1'b1;
                     ph   <= BC_HOLD;
                     cnt  <= CW'(T_HLD - 1);
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            BC_HOLD: begin
               if (cnt == '0) begin
                  ce_n <= 1'b1;
                  d_oe <= 1'b0;
                  ph   <= BC_RECOV;
                  cnt  <= CW'(T_REC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            BC_RECOV: begin
               if (cnt == '0) begin
                  ph   <= BC_IDLE;
                  done <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: ph <= BC_IDLE;
         endcase
      end
   end

   // R7: the bus is never driven while the flash may be driving it
   p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !d_oe);
   // R7: strobes never overlap
   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n));
   // R6: write strobe only inside a chip-enable window
   p_we_in_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ce_n);
   // R6: address steady for the whole chip-enable window
   p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && $past(!ce_n)) |-> $stable(a_o));
   // R6: driven data steady while chip enable stays low
   p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && $past(!ce_n) && d_oe) |-> $stable(d_o));
endmodule

// File: rtl/fseq_poll_eval.sv
module fseq_poll_eval #(
   parameter int DW        = 8,
   parameter bit TOGGLE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          rd_valid,
   input  logic [DW-1:0] rd_data,
   input  logic          prog_mode,
   input  logic [DW-1:0] exp_byte,
   output logic          hit
);
   localparam int B_POLL = DW - 1;
   localparam int B_TOG  = DW - 2;

   if (DW < 2) begin : g_bad_width
      $error("fseq_poll_eval: data width too small for status bits");
   end

   logic match;
   logic tog_stop;

   assign match = prog_mode ? (rd_data[B_POLL] == exp_byte[B_POLL]) : (&rd_data);

   if (TOGGLE_EN) begin : g_toggle
      logic prev_b;
      logic have_prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_b    <= 1'b0;
            have_prev <= 1'b0;
         end else if (clr) begin
            have_prev <= 1'b0;
         end else if (rd_valid) begin
            prev_b    <= rd_data[B_TOG];
            have_prev <= 1'b1;
         end
      end
      assign tog_stop = have_prev && (rd_data[B_TOG] == prev_b);
   end else begin : g_no_toggle
      assign tog_stop = 1'b0;
   end

   assign hit = rd_valid && (match || tog_stop);
endmodule

// File: rtl/fseq_watchdog.sv
module fseq_watchdog
   import fseq_pkg::*;
#(
   parameter int LIM_A = 12500,
   parameter int LIM_B = 25000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic sel_a,
   output logic expired
);
   localparam int LMAX = fseq_max(LIM_A, LIM_B);
   localparam int WW   = $clog2(LMAX + 1);

   if (LIM_A < 1 || LIM_B < 1) begin : g_bad_limit
      $error("fseq_watchdog: limits must be positive");
   end

   logic [WW-1:0] cnt;
   logic [WW-1:0] lim;

   assign lim = sel_a ? WW'(LIM_A) : WW'(LIM_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (cnt != WW'(LMAX)) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt >= lim);

   // R8/R9: once expired inside one polling phase, it stays expired
   p_wd_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $past(expired) && $stable(sel_a)) |-> expired);
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
   import fseq_pkg::*;
#(
   parameter int ADDR_W      = 18,
   parameter int LEN_W       = 19,
   parameter int T_SU        = 1,
   parameter int T_WP        = 9,
   parameter int T_HLD       = 3,
   parameter int T_REC       = 5,
   parameter int T_RD        = 15,
   parameter int PROG_LIMIT  = 12500,
   parameter int ERASE_LIMIT = 25000000,
   parameter int UNLOCK_A1   = 'h555,
   parameter int UNLOCK_A2   = 'h2AA,
   parameter bit TOGGLE_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [7:0]        src_data,
   output logic              op_done,
   output logic              op_timeout,
   output logic              fl_ce_n,
   output logic              fl_we_n,
   output logic              fl_oe_n,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_dq_o,
   output logic              fl_dq_oe,
   input  logic [7:0]        fl_dq_i
);
   localparam int DW        = FSEQ_DW;
   localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNLOCK_A1);
   localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNLOCK_A2);
   localparam logic [2:0] LAST_PROG  = 3'd2;
   localparam logic [2:0] LAST_ERASE = 3'd5;

   if (ADDR_W < 11) begin : g_bad_addr
      $error("flash_pe_seq: address too narrow for unlock addresses");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("flash_pe_seq: length width must be positive");
   end

   fseq_state_e       st;
   fseq_op_e          op_q;
   logic [2:0]        idx;
   logic              waiting;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  remain;
   logic [DW-1:0]     wbyte;

   logic              bus_start, bus_rd, bus_done;
   logic [ADDR_W-1:0] bus_a;
   logic [DW-1:0]     bus_d, bus_rdata;
   logic [ADDR_W-1:0] cmd_a;
   logic [DW-1:0]     cmd_d;
   logic              is_prog;
   logic              poll_hit, wd_expired;
   logic [2:0]        last_idx;

   assign is_prog  = (op_q == OP_PROG);
   assign last_idx = is_prog ? LAST_PROG : LAST_ERASE;

   // command word for the current step of the unlock / command sequence
   always_comb begin
      unique case (idx)
         3'd0:    begin cmd_a = A1; cmd_d = 8'hAA; end
         3'd1:    begin cmd_a = A2; cmd_d = 8'h55; end
         3'd2:    begin cmd_a = A1; cmd_d = is_prog ? 8'hA0 : 8'h80; end
         3'd3:    begin cmd_a = A1; cmd_d = 8'hAA; end
         3'd4:    begin cmd_a = A2; cmd_d = 8'h55; end
         default: begin
            if (op_q == OP_CERASE) begin cmd_a = A1;       cmd_d = 8'h10; end
            else                   begin cmd_a = cur_addr; cmd_d = 8'h30; end
         end
      endcase
   end

   always_comb begin
      bus_start = 1'b0;
      bus_rd    = 1'b0;
      bus_a     = cur_addr;
      bus_d     = src_data;
      src_ready = 1'b0;
      unique case (st)
         ST_CMD: if (!waiting) begin
            bus_start = 1'b1;
            bus_a     = cmd_a;
            bus_d     = cmd_d;
         end
         ST_DATA: if (!waiting && src_valid) begin
            bus_start = 1'b1;
            src_ready = 1'b1;
         end
         ST_POLL: if (!waiting) begin
            bus_start = 1'b1;
            bus_rd    = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_q     <= OP_PROG;
         idx      <= '0;
         waiting  <= 1'b0;
         cur_addr <= '0;
         remain   <= '0;
         wbyte    <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  op_q     <= fseq_op_e'(req_op);
                  cur_addr <= req_addr;
                  remain   <= req_len;
                  idx      <= '0;
                  waiting  <= 1'b0;
                  if (req_op == OP_RSVD || (req_op == OP_PROG && req_len == '0))
                     st <= ST_OK;
                  else
                     st <= ST_CMD;
               end
            end
            ST_CMD: begin
               if (bus_start) waiting <= 1'b1;
               if (bus_done) begin
                  waiting <= 1'b0;
                  if (idx == last_idx) begin
                     idx <= '0;
                     st  <= is_prog ? ST_DATA : ST_POLL;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (bus_start) begin
                  waiting <= 1'b1;
                  wbyte   <= src_data;
               end
               if (bus_done) begin
                  waiting <= 1'b0;
                  st      <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (bus_start) waiting <= 1'b1;
               if (bus_done) begin
                  waiting <= 1'b0;
                  if (poll_hit) begin
                     if (is_prog && remain > LEN_W'(1)) begin
                        remain   <= remain - 1'b1;
                        cur_addr <= cur_addr + 1'b1;
                        st       <= ST_CMD;
                     end else begin
                        st <= ST_OK;
                     end
                  end else if (wd_expired) begin
                     st <= ST_ERR;
                  end
               end
            end
            ST_OK:   st <= ST_IDLE;
            ST_ERR:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (st == ST_IDLE);
   assign op_done    = (st == ST_OK);
   assign op_timeout = (st == ST_ERR);

   fseq_bus_cycle #(
      .ADDR_W(ADDR_W), .DW(DW), .T_SU(T_SU), .T_WP(T_WP),
      .T_HLD(T_HLD), .T_REC(T_REC), .T_RD(T_RD)
   ) i_bus (
      .clk(clk), .rst_n(rst_n), .start(bus_start), .rd(bus_rd),
      .addr(bus_a), .wdata(bus_d), .done(bus_done), .rdata(bus_rdata),
      .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n), .a_o(fl_addr),
      .d_o(fl_dq_o), .d_oe(fl_dq_oe), .d_i(fl_dq_i)
   );

   fseq_poll_eval #(.DW(DW), .TOGGLE_EN(TOGGLE_EN)) i_poll (
      .clk(clk), .rst_n(rst_n), .clr(st != ST_POLL),
      .rd_valid(bus_done && st == ST_POLL), .rd_data(bus_rdata),
      .prog_mode(is_prog), .exp_byte(wbyte), .hit(poll_hit)
   );

   fseq_watchdog #(.LIM_A(PROG_LIMIT), .LIM_B(ERASE_LIMIT)) i_wd (
      .clk(clk), .rst_n(rst_n), .run(st == ST_POLL), .sel_a(is_prog),
      .expired(wd_expired)
   );

   // R2: source bytes are only taken by program requests
   p_src_prog_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> (op_q == OP_PROG && src_valid));
   // R11: an accepted request drops ready on the next cycle
   p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> !req_ready);
   // R8: a timeout only follows a completed status read
   p_timeout_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_timeout |-> $past(bus_done));
   // R3: done and timeout never coincide
   p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_done && op_timeout));
endmodule

// File: tb/test_flash_pe_seq.sv
module test_flash_pe_seq;
   localparam int AW = 12, LW = 5;
   localparam int TSU = 1, TWP = 3, THLD = 2, TREC = 2, TRD = 2;
   localparam int PLIM = 200, ELIM = 600;
   localparam int PROG_T = 40, ERASE_T = 150;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic req_ready, src_ready, src_valid, op_done, op_timeout;
   logic [7:0] src_data;
   logic fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
   logic [AW-1:0] fl_addr;
   logic [7:0] fl_dq_o, fl_dq_i;

   always #2 clk = ~clk;

   int errors = 0, checks = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // source stream
   logic [7:0] sbuf [0:31];
   int sidx = 0, slen = 0;
   assign src_valid = (sidx < slen);
   assign src_data  = sbuf[sidx[4:0]];

   flash_pe_seq #(
      .ADDR_W(AW), .LEN_W(LW), .T_SU(TSU), .T_WP(TWP), .T_HLD(THLD),
      .T_REC(TREC), .T_RD(TRD), .PROG_LIMIT(PLIM), .ERASE_LIMIT(ELIM)
   ) i_flash_pe_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .op_done(op_done), .op_timeout(op_timeout),
      .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
      .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
   );

   // ---------------- flash model ----------------
   logic [7:0] mem [0:4095];
   logic [AW-1:0] log_a [0:63];
   logic [7:0] log_d [0:63];
   int nw = 0, nr = 0, cst = 0, busy_until = 0;
   bit stuck_mode = 0, stale_mode = 0, last_prog = 0, last_d7 = 0, tog = 0;
   logic [AW-1:0] lat_a;
   logic busy;
   assign busy = stuck_mode || (cyc < busy_until);

   initial for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 29 + 3);

   always @(negedge fl_we_n) if (rst_n && !fl_ce_n) lat_a = fl_addr;

   always @(posedge fl_we_n) begin
      if (rst_n && !fl_ce_n) begin
         if (nw < 64) begin log_a[nw] = lat_a; log_d[nw] = fl_dq_o; end
         nw++;
         case (cst)
            0: cst = (lat_a == 12'h555 && fl_dq_o == 8'hAA) ? 1 : 0;
            1: cst = (lat_a == 12'h2AA && fl_dq_o == 8'h55) ? 2 : 0;
            2: if (lat_a == 12'h555 && fl_dq_o == 8'hA0) cst = 3;
               else if (lat_a == 12'h555 && fl_dq_o == 8'h80) cst = 4;
               else cst = 0;
            3: begin
               mem[lat_a] = mem[lat_a] & fl_dq_o;
               last_d7 = fl_dq_o[7]; last_prog = 1;
               busy_until = cyc + PROG_T; cst = 0;
            end
            4: cst = (lat_a == 12'h555 && fl_dq_o == 8'hAA) ? 5 : 0;
            5: cst = (lat_a == 12'h2AA && fl_dq_o == 8'h55) ? 6 : 0;
            default: begin
               if (lat_a == 12'h555 && fl_dq_o == 8'h10) begin
                  for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
                  last_prog = 0; busy_until = cyc + ERASE_T;
               end else if (fl_dq_o == 8'h30) begin
                  for (int i = 0; i < 1024; i++) mem[{lat_a[11:10], 10'(i)}] = 8'hFF;
                  last_prog = 0; busy_until = cyc + ERASE_T;
               end
               cst = 0;
            end
         endcase
      end
   end

   always @(posedge fl_oe_n) if (rst_n) begin
      nr++;
      if (busy) tog = ~tog;
   end

   always @* begin
      if (busy)
         fl_dq_i = last_prog ? {~last_d7, tog, 6'd0} : {1'b0, tog, 6'd0};
      else if (stale_mode)
         fl_dq_i = last_prog ? {~last_d7, mem[fl_addr][6:0]} : {1'b0, mem[fl_addr][6:0]};
      else
         fl_dq_i = mem[fl_addr];
   end

   // ---------------- bus monitor ----------------
   int wl = 0, rl = 0, cl = 0, ch = 0, viol = 0, ndone = 0, ntmo = 0, ncef = 0;
   int we_rise_cyc = 0, tmo_cyc = 0;
   bit ep_wr = 0, had_ep = 0;
   always @(negedge clk) if (rst_n) begin
      if (op_done) ndone++;
      if (op_timeout) begin ntmo++; tmo_cyc = cyc; end
      if (!fl_oe_n && fl_dq_oe) viol++;
      if (fl_dq_oe && fl_ce_n) viol++;
      if (!fl_we_n) begin wl++; ep_wr = 1; end
      else if (wl != 0) begin if (wl != TWP) viol++; wl = 0; we_rise_cyc = cyc; end
      if (!fl_oe_n) rl++;
      else if (rl != 0) begin if (rl != TRD) viol++; rl = 0; end
      if (!fl_ce_n) begin
         if (cl == 0) begin
            ncef++;
            if (had_ep && ch < TREC) viol++;
         end
         cl++; ch = 0;
      end else begin
         if (cl != 0) begin
            if (ep_wr && cl != TSU + TWP + THLD) viol++;
            if (!ep_wr && cl != TSU + TRD) viol++;
            cl = 0; ep_wr = 0; had_ep = 1;
         end
         ch++;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic feeder();
      forever begin
         @(negedge clk);
         if (src_ready) begin @(posedge clk); #1; sidx++; end
      end
   endtask

   task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                         input int len);
      nw = 0; nr = 0; ndone = 0; ntmo = 0; ncef = 0; sidx = 0; slen = len;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_len = LW'(len);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      for (int w = 0; w < 4000 && ndone == 0 && ntmo == 0; w++) begin
         @(negedge clk); #1;
      end
      repeat (3) @(negedge clk);
      #1;
   endtask

   function automatic logic [7:0] pat(input int s, input int i, input int len);
      return 8'(s + i * 91 + len * 17) ^ 8'hC3;
   endfunction

   function automatic logic [AW-1:0] exp_wa(input logic [AW-1:0] s, input int k);
      case (k % 4)
         0: return 12'h555;
         1: return 12'h2AA;
         2: return 12'h555;
         default: return s + AW'(k / 4);
      endcase
   endfunction

   int bad;

   initial begin
      fork feeder(); join_none
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1", "bus idle in reset",
          {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(req_ready && !op_done && !op_timeout && fl_ce_n, "R1", "ready after reset",
          {req_ready, op_done, op_timeout}, 3'b100);

      // R5 chip erase
      run_op(2'b10, 12'h123, 0);
      chk(ndone == 1 && ntmo == 0, "R5", "chip erase done", ndone, 1);
      chk(nw == 6 && log_a[5] == 12'h555 && log_d[5] == 8'h10, "R5", "final chip erase write",
          {log_a[5], log_d[5]}, 20'h55510);
      bad = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] != 8'hFF) bad++;
      chk(bad == 0, "R5", "array blank", bad, 0);
      chk(log_a[2] == 12'h555 && log_d[2] == 8'h80 && log_d[3] == 8'hAA && log_d[4] == 8'h55,
          "R5", "command prefix", log_d[2], 8'h80);

      // R2/R3 program sweep
      for (int k = 0; k < 3; k++) begin
         for (int len = 1; len <= 4; len++) begin
            logic [AW-1:0] s;
            s = AW'(12'h0F0 + k * 12'h155 + len * 8);
            for (int i = 0; i < len; i++) sbuf[i] = pat(s, i, len);
            run_op(2'b00, s, len);
            chk(ndone == 1 && ntmo == 0, "R3", "program done", ndone, 1);
            bad = 0;
            for (int j = 0; j < 4 * len; j++) begin
               logic [7:0] ed;
               case (j % 4)
                  0: ed = 8'hAA; 1: ed = 8'h55; 2: ed = 8'hA0;
                  default: ed = pat(s, j / 4, len);
               endcase
               if (log_a[j] != exp_wa(s, j) || log_d[j] != ed) bad++;
            end
            chk(bad == 0 && nw == 4 * len, "R2", "write sequence", nw, 4 * len);
            bad = 0;
            for (int i = 0; i < len; i++) if (mem[s + AW'(i)] != pat(s, i, len)) bad++;
            chk(bad == 0 && sidx == len, "R2", "bytes stored and consumed", sidx, len);
         end
      end
      chk(viol == 0, "R6", "write cycle timing", viol, 0);
      chk(viol == 0, "R7", "read cycle timing and bus release", viol, 0);

      // R3 completion through bit 6 only
      stale_mode = 1;
      sbuf[0] = 8'h85; sbuf[1] = 8'h3C;
      run_op(2'b00, 12'h600, 2);
      chk(ndone == 1 && ntmo == 0, "R3", "toggle-stop completion", ntmo, 0);
      chk(mem[12'h600] == 8'h85 && mem[12'h601] == 8'h3C && nw == 8, "R3", "stored via toggle", nw, 8);
      stale_mode = 0;

      // R8 program timeout
      stuck_mode = 1;
      sbuf[0] = 8'h11; sbuf[1] = 8'h22; sbuf[2] = 8'h33;
      run_op(2'b00, 12'h700, 3);
      chk(ntmo == 1 && ndone == 0, "R8", "program timeout", ntmo, 1);
      chk(nw == 4 && sidx == 1, "R8", "rest abandoned", nw, 4);
      chk(tmo_cyc - we_rise_cyc >= PLIM && tmo_cyc - we_rise_cyc <= PLIM + 20, "R8",
          "timeout latency", tmo_cyc - we_rise_cyc, PLIM);
      stuck_mode = 0;

      // R4 block erase at unaligned address
      sbuf[0] = 8'h5A; run_op(2'b00, 12'h500, 1);
      sbuf[0] = 8'h66; run_op(2'b00, 12'h810, 1);
      run_op(2'b01, 12'h4A3, 0);
      chk(ndone == 1 && nw == 6, "R4", "block erase writes", nw, 6);
      chk(log_a[5] == 12'h4A3 && log_d[5] == 8'h30, "R4", "final block write",
          {log_a[5], log_d[5]}, 20'h4A330);
      chk(mem[12'h500] == 8'hFF && mem[12'h810] == 8'h66 && mem[12'h0F8] != 8'hFF, "R4",
          "only target block blank", mem[12'h810], 8'h66);

      // R4 erase completion via bit 6 only
      stale_mode = 1;
      run_op(2'b01, 12'hC40, 0);
      chk(ndone == 1 && ntmo == 0, "R4", "erase toggle-stop completion", ndone, 1);
      stale_mode = 0;

      // R9 erase timeout
      stuck_mode = 1;
      run_op(2'b01, 12'hC00, 0);
      chk(ntmo == 1 && ndone == 0, "R9", "erase timeout", ntmo, 1);
      chk(tmo_cyc - we_rise_cyc >= ELIM && tmo_cyc - we_rise_cyc <= ELIM + 20, "R9",
          "erase timeout latency", tmo_cyc - we_rise_cyc, ELIM);
      stuck_mode = 0;

      // R10 zero length and reserved code
      run_op(2'b00, 12'h300, 0);
      chk(ndone == 1 && ncef == 0 && sidx == 0, "R10", "zero length no bus", ncef, 0);
      run_op(2'b11, 12'h300, 3);
      chk(ndone == 1 && ncef == 0 && sidx == 0, "R10", "reserved code no bus", ncef, 0);

      // R11 request during busy ignored
      nw = 0; ndone = 0; ntmo = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b01; req_addr = 12'hC08; req_len = '0;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (60) @(negedge clk);
      #1;
      chk(!req_ready, "R11", "not ready while busy", req_ready, 0);
      req_valid = 1'b1; req_op = 2'b10;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      for (int w = 0; w < 4000 && ndone == 0; w++) begin @(negedge clk); #1; end
      repeat (40) @(negedge clk);
      #1;
      chk(nw == 6 && ndone == 1, "R11", "mid-op request ignored", nw, 6);
      chk(mem[12'h810] == 8'h66, "R11", "no chip erase ran", mem[12'h810], 8'h66);
      chk(viol == 0, "R6", "timing over all operations", viol, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule